// File: doc/BRIEF.md
# Ping-pong waveform capture controller

This block steers hits from one photosensor front end into two switched-capacitor waveform digitizers used in alternation. When the discriminator fires, the block arms an idle digitizer, latches a coarse 48-bit timestamp and the set of channels to convert, and waits a programmable number of clock ticks for a neighbour-coincidence tag. A tagged capture is converted through a start/done handshake and then read out. A capture with no tag in time is dropped, and its digitizer is freed without conversion.

While one digitizer converts or is read out, the other stays ready for the next trigger. Each stored hit leaves the block as one record on a valid/ready stream. The first word of a record is a header. The header is followed by the samples of every selected channel, in ascending channel order and ascending sample index. Samples are fetched through a combinational read port (digitizer, channel, index in; data back in the same cycle). Triggers that find both digitizers busy are counted in a dead-time counter.

Top module: `pingpong_capture`

## Requirements
- R1: After reset, `out_valid` is low, `dead_cnt` is 0 and both `conv_start` bits are low.
- R2: A trigger goes to the digitizer not chosen by the previous accepted trigger if that one is idle, otherwise to the other idle one. The first trigger after reset goes to digitizer 0.
- R3: With window W, a tag sampled on clock edge k after the trigger edge is accepted when 1 <= k <= W. W = 0 accepts no tag.
- R4: A capture without an accepted tag produces no `conv_start` and no record, and its digitizer becomes idle again.
- R5: An accepted tag gives exactly one cycle of `conv_start` for that digitizer. `conv_done` is honoured any number of cycles after that pulse, including the very next cycle.
- R6: A header word has bit 63 = 1, timestamp in [47:0], digitizer in [48], channel mask in [52:49], tag flag = 1 in [53], and all other bits 0. A sample word has the value in [9:0], the channel in [17:16] and all other bits 0. Samples are sent channel by channel in ascending order, indices 0..127. `out_last` marks the final word, which is the header itself when the mask is 0.
- R7: Sample words carry the `rd_data` value read at the address (`rd_dig`, `rd_chan`, `rd_idx`) of the hit's digitizer, channel and index.
- R8: The coarse counter is 0 out of reset and advances every clock. The timestamp is its value in the trigger cycle. The mask is the `chan_mask` value in the trigger cycle.
- R9: A trigger that finds both digitizers busy is dropped, and `dead_cnt` increments, saturating at 65535.
- R10: While `out_valid` is high and `out_ready` low, `out_valid`, `out_data` and `out_last` hold.
- R11: A converted hit is sent as soon as the output is free. When both digitizers hold converted hits, the older timestamp goes first.
- R12: One tag is accepted by every digitizer whose window is open at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one coarse tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Discriminator trigger, one trigger per high cycle |
| chan_mask | input | 4 | Channels to convert for this trigger |
| win_ticks | input | 8 | Coincidence window length in ticks |
| coinc_tag | input | 1 | Neighbour-coincidence tag |
| conv_start | output | 2 | Conversion start pulse per digitizer |
| conv_done | input | 2 | Conversion finished per digitizer |
| rd_dig | output | 1 | Readout digitizer select |
| rd_chan | output | 2 | Readout channel select |
| rd_idx | output | 7 | Readout sample index |
| rd_data | input | 10 | Sample value at the readout address |
| out_valid | output | 1 | Record word valid |
| out_ready | input | 1 | Downstream accepts word |
| out_data | output | 64 | Record word |
| out_last | output | 1 | Final word of a record |
| dead_cnt | output | 16 | Dropped-trigger counter |

## Verification
The bench probes both edges of the coincidence window (k = W and k = W + 1, plus W = 0). A design off by one edge would store a hit it should drop, or lose one it should keep. It fires two triggers one cycle apart with one shared tag and unequal conversion times. This checks that both captures are tagged and that the faster conversion is sent first. A third trigger in that state must be counted and must leave no record. A long run of triggers while both digitizers are busy drives the dead-time counter into saturation; a wrapping counter would show a small value. Both digitizers then finish in the same cycle, so only the timestamp decides which record is sent first. Random masks (zero included), zero-delay conversions and random backpressure test record framing, the channel order and holding of the output.

// File: rtl/capture_pkg.sv
package capture_pkg;
    typedef enum logic [2:0] {
        SL_IDLE  = 3'd0,
        SL_ARMED = 3'd1,
        SL_START = 3'd2,
        SL_WAIT  = 3'd3,
        SL_FULL  = 3'd4
    } slot_state_e;

    localparam int NDIG = 2;
endpackage

// File: rtl/capture_slot.sv
module capture_slot
    import capture_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int WINW = 8,
    parameter int TSW  = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go_i,
    input  logic [TSW-1:0]  ts_i,
    input  logic [NCH-1:0]  mask_i,
    input  logic [WINW-1:0] win_i,
    input  logic            tag_i,
    input  logic            done_i,
    input  logic            release_i,
    output logic            busy_o,
    output logic            full_o,
    output logic            start_o,
    output logic [TSW-1:0]  ts_o,
    output logic [NCH-1:0]  mask_o
);
    typedef struct packed {
        slot_state_e     st;
        logic [WINW-1:0] cnt;
        logic [TSW-1:0]  ts;
        logic [NCH-1:0]  mask;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            SL_IDLE: begin
                if (go_i) begin
                    s_d.st   = SL_ARMED;
                    s_d.cnt  = '0;
                    s_d.ts   = ts_i;
                    s_d.mask = mask_i;
                end
            end
            SL_ARMED: begin
                if (s_q.cnt >= win_i)  s_d.st  = SL_IDLE;
                else if (tag_i)        s_d.st  = SL_START;
                else                   s_d.cnt = s_q.cnt + WINW'(1);
            end
            SL_START: s_d.st = SL_WAIT;
            SL_WAIT:  if (done_i) s_d.st = SL_FULL;
            SL_FULL:  if (release_i) s_d.st = SL_IDLE;
            default:  s_d.st = SL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o  = (s_q.st != SL_IDLE);
    assign full_o  = (s_q.st == SL_FULL);
    assign start_o = (s_q.st == SL_START);
    assign ts_o    = s_q.ts;
    assign mask_o  = s_q.mask;

    assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    assert_start_needs_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(tag_i));
    assert_full_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !release_i) |=> full_o);
endmodule

// File: rtl/capture_emitter.sv
module capture_emitter
    import capture_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int NSAMP = 128,
    parameter int SMPW  = 10,
    parameter int TSW   = 48,
    parameter int OUTW  = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NDIG-1:0]           full_i,
    input  logic [NDIG-1:0][TSW-1:0]  ts_i,
    input  logic [NDIG-1:0][NCH-1:0]  mask_i,
    input  logic [SMPW-1:0]           rd_data,
    input  logic                      out_ready,
    output logic [NDIG-1:0]           rel_o,
    output logic                      rd_dig,
    output logic [((NCH>1)?$clog2(NCH):1)-1:0] rd_chan,
    output logic [((NSAMP>1)?$clog2(NSAMP):1)-1:0] rd_idx,
    output logic                      out_valid,
    output logic [OUTW-1:0]           out_data,
    output logic                      out_last
);
    localparam int CHW      = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int IW       = (NSAMP > 1) ? $clog2(NSAMP) : 1;
    localparam int HDR_DIG  = TSW;
    localparam int HDR_MASK = TSW + 1;
    localparam int HDR_TAG  = TSW + 1 + NCH;
    localparam int SMP_CH   = 16;

    typedef struct packed {
        logic            active;
        logic            sel;
        logic [CHW-1:0]  ch;
        logic [IW-1:0]   idx;
        logic            vld;
        logic            last;
        logic [OUTW-1:0] data;
    } emit_t;

    emit_t e_d, e_q;
    logic [CHW:0] nx;
    logic         pick;

    function automatic logic [CHW:0] first_set(input logic [NCH-1:0] m, input int from);
        logic [CHW:0] r;
        r = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (i >= from && m[i]) r = {1'b1, CHW'(i)};
        end
        return r;
    endfunction

    always_comb begin
        e_d   = e_q;
        rel_o = '0;
        nx    = '0;
        pick  = (full_i == 2'b11) ? (ts_i[1] < ts_i[0]) : full_i[1];
        if (!e_q.vld || out_ready) begin
            if (e_q.active) begin
                e_d.vld                   = 1'b1;
                e_d.data                  = '0;
                e_d.data[SMPW-1:0]        = rd_data;
                e_d.data[SMP_CH +: CHW]   = e_q.ch;
                if (e_q.idx == IW'(NSAMP - 1)) begin
                    nx = first_set(mask_i[e_q.sel], int'(e_q.ch) + 1);
                    if (nx[CHW]) begin
                        e_d.ch   = nx[CHW-1:0];
                        e_d.idx  = '0;
                        e_d.last = 1'b0;
                    end else begin
                        e_d.last       = 1'b1;
                        e_d.active     = 1'b0;
                        rel_o[e_q.sel] = 1'b1;
                    end
                end else begin
                    e_d.idx  = e_q.idx + IW'(1);
                    e_d.last = 1'b0;
                end
            end else if (|full_i) begin
                e_d.vld                     = 1'b1;
                e_d.sel                     = pick;
                e_d.data                    = '0;
                e_d.data[TSW-1:0]           = ts_i[pick];
                e_d.data[HDR_DIG]           = pick;
                e_d.data[HDR_MASK +: NCH]   = mask_i[pick];
                e_d.data[HDR_TAG]           = 1'b1;
                e_d.data[OUTW-1]            = 1'b1;
                e_d.idx                     = '0;
                nx = first_set(mask_i[pick], 0);
                if (nx[CHW]) begin
                    e_d.active = 1'b1;
                    e_d.ch     = nx[CHW-1:0];
                    e_d.last   = 1'b0;
                end else begin
                    e_d.last    = 1'b1;
                    rel_o[pick] = 1'b1;
                end
            end else begin
                e_d.vld  = 1'b0;
                e_d.last = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign rd_dig    = e_q.sel;
    assign rd_chan   = e_q.ch;
    assign rd_idx    = e_q.idx;
    assign out_valid = e_q.vld;
    assign out_data  = e_q.data;
    assign out_last  = e_q.last;

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
    assert_last_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
endmodule

// File: rtl/pingpong_capture.sv
module pingpong_capture
    import capture_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int NSAMP = 128,
    parameter int SMPW  = 10,
    parameter int TSW   = 48,
    parameter int WINW  = 8,
    parameter int DEADW = 16,
    parameter int OUTW  = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trig,
    input  logic [NCH-1:0]  chan_mask,
    input  logic [WINW-1:0] win_ticks,
    input  logic            coinc_tag,
    output logic [1:0]      conv_start,
    input  logic [1:0]      conv_done,
    output logic            rd_dig,
    output logic [((NCH>1)?$clog2(NCH):1)-1:0] rd_chan,
    output logic [((NSAMP>1)?$clog2(NSAMP):1)-1:0] rd_idx,
    input  logic [SMPW-1:0] rd_data,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [OUTW-1:0] out_data,
    output logic            out_last,
    output logic [DEADW-1:0] dead_cnt
);
    typedef struct packed {
        logic [TSW-1:0]   cnt;
        logic             pref;
        logic [DEADW-1:0] dead;
    } top_t;

    top_t t_d, t_q;
    logic [NDIG-1:0]          go, busy, full, rel;
    logic [NDIG-1:0][TSW-1:0] slot_ts;
    logic [NDIG-1:0][NCH-1:0] slot_mask;

    always_comb begin
        t_d     = t_q;
        go      = '0;
        t_d.cnt = t_q.cnt + TSW'(1);
        if (trig) begin
            if (!busy[t_q.pref]) begin
                go[t_q.pref] = 1'b1;
                t_d.pref     = ~t_q.pref;
            end else if (!busy[~t_q.pref]) begin
                go[~t_q.pref] = 1'b1;
            end else if (t_q.dead != '1) begin
                t_d.dead = t_q.dead + DEADW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign dead_cnt = t_q.dead;

    for (genvar g = 0; g < NDIG; g++) begin : g_slot
        capture_slot #(.NCH(NCH), .WINW(WINW), .TSW(TSW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .go_i      (go[g]),
            .ts_i      (t_q.cnt),
            .mask_i    (chan_mask),
            .win_i     (win_ticks),
            .tag_i     (coinc_tag),
            .done_i    (conv_done[g]),
            .release_i (rel[g]),
            .busy_o    (busy[g]),
            .full_o    (full[g]),
            .start_o   (conv_start[g]),
            .ts_o      (slot_ts[g]),
            .mask_o    (slot_mask[g])
        );
    end

    capture_emitter #(.NCH(NCH), .NSAMP(NSAMP), .SMPW(SMPW), .TSW(TSW), .OUTW(OUTW)) u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .full_i    (full),
        .ts_i      (slot_ts),
        .mask_i    (slot_mask),
        .rd_data   (rd_data),
        .out_ready (out_ready),
        .rel_o     (rel),
        .rd_dig    (rd_dig),
        .rd_chan   (rd_chan),
        .rd_idx    (rd_idx),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    assert_dead_mono_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> dead_cnt >= $past(dead_cnt));
    assert_dead_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dead_cnt == '1) |=> (dead_cnt == '1));
    assert_drop_counts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && (&busy) && dead_cnt != '1) |=> (dead_cnt != $past(dead_cnt)));
    assert_free_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !(&busy)) |=> (dead_cnt == $past(dead_cnt)));
endmodule

// File: tb/pingpong_capture_bench.sv
`timescale 1ns/1ps
module pingpong_capture_bench;
    localparam int NSAMP = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic [3:0]  chan_mask = '0;
    logic [7:0]  win_ticks = '0;
    logic        coinc_tag = 1'b0;
    logic [1:0]  conv_start;
    logic [1:0]  conv_done = '0;
    logic        rd_dig;
    logic [1:0]  rd_chan;
    logic [6:0]  rd_idx;
    logic [9:0]  rd_data;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [63:0] out_data;
    logic        out_last;
    logic [15:0] dead_cnt;

    typedef struct {
        logic [47:0] ts;
        logic        dig;
        logic [3:0]  mask;
    } rec_t;

    rec_t        expq[$];
    int          pos = 0;
    int          checks = 0;
    int          errors = 0;
    logic [63:0] bcyc;
    bit          bpref = 1'b0;
    int          conv_dly[2];
    int          nstart[2];
    int          cd_cnt[2];
    bit          cd_pend[2];
    int          rdy_pct = 100;
    bit          hold_pend = 1'b0;
    logic [63:0] hold_data;
    bit          fin = 1'b0;

    always #4 clk = ~clk;

    pingpong_capture u_pingpong_capture (
        .clk(clk), .rst_n(rst_n), .trig(trig), .chan_mask(chan_mask),
        .win_ticks(win_ticks), .coinc_tag(coinc_tag), .conv_start(conv_start),
        .conv_done(conv_done), .rd_dig(rd_dig), .rd_chan(rd_chan), .rd_idx(rd_idx),
        .rd_data(rd_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last), .dead_cnt(dead_cnt)
    );

    function automatic logic [9:0] smp(input logic d, input logic [1:0] c, input logic [6:0] i);
        return {d, c, i};
    endfunction

    assign rd_data = smp(rd_dig, rd_chan, rd_idx);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [64:0] exp_beat(input rec_t r, input int p);
        logic [63:0] d;
        logic        l;
        int          q, which, idx, n, ch;
        d = '0;
        if (p == 0) begin
            d = {1'b1, 9'b0, 1'b1, r.mask, r.dig, r.ts};
            l = (r.mask == 4'b0);
        end else begin
            q     = p - 1;
            which = q / NSAMP;
            idx   = q % NSAMP;
            n     = 0;
            ch    = 0;
            for (int c = 0; c < 4; c++) begin
                if (r.mask[c]) begin
                    if (n == which) ch = c;
                    n++;
                end
            end
            d[9:0]   = smp(r.dig, 2'(ch), 7'(idx));
            d[17:16] = 2'(ch);
            l = (q == n * NSAMP - 1);
        end
        return {l, d};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) bcyc <= '0;
        else        bcyc <= bcyc + 64'd1;
    end

    // conversion model: done arrives conv_dly cycles after the one seen start
    always @(negedge clk) begin
        for (int d = 0; d < 2; d++) begin
            conv_done[d] = 1'b0;
            if (cd_pend[d]) begin
                if (cd_cnt[d] == 0) begin
                    conv_done[d] = 1'b1;
                    cd_pend[d]   = 1'b0;
                end else begin
                    cd_cnt[d]--;
                end
            end
            if (conv_start[d] === 1'b1) begin
                cd_pend[d] = 1'b1;
                cd_cnt[d]  = conv_dly[d];
                nstart[d]++;
            end
        end
    end

    // output monitor
    always @(negedge clk) begin
        logic [64:0] e;
        if (rst_n) begin
            if (hold_pend)
                chk(out_valid && out_data == hold_data, "R10 hold under backpressure", out_data, hold_data);
            out_ready = (($urandom % 100) < rdy_pct);
            hold_pend = out_valid && !out_ready;
            hold_data = out_data;
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R4/R6 unexpected record word", out_data, 64'd0);
                end else begin
                    e = exp_beat(expq[0], pos);
                    chk(out_data == e[63:0], (pos == 0) ? "R2/R6/R8/R11 header" : "R6/R7 sample",
                        out_data, e[63:0]);
                    chk(out_last == e[64], "R6 last flag", 64'(out_last), 64'(e[64]));
                    if (e[64]) begin
                        void'(expq.pop_front());
                        pos = 0;
                    end else begin
                        pos++;
                    end
                end
            end
        end
    end

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 20) begin
            @(negedge clk);
            if (expq.size() == 0 && !out_valid) quiet++;
            else quiet = 0;
        end
    endtask

    task automatic single_hit(input logic [3:0] m, input int win, input int k, input bit tag_on, input int dly);
        rec_t r;
        bit   acc;
        int   d, c0;
        logic [15:0] dead0;
        @(negedge clk);
        chan_mask   = m;
        win_ticks   = 8'(win);
        d           = int'(bpref);
        conv_dly[d] = dly;
        c0          = nstart[d];
        dead0       = dead_cnt;
        trig        = 1'b1;
        r.ts = bcyc[47:0]; r.dig = bpref; r.mask = m;
        acc = tag_on && (k >= 1) && (k <= win);
        if (acc) expq.push_back(r);
        bpref = ~bpref;
        for (int i = 1; i <= k; i++) begin
            @(negedge clk);
            trig = 1'b0;
            chan_mask = ~m;
            if (i == k && tag_on) coinc_tag = 1'b1;
        end
        @(negedge clk);
        coinc_tag = 1'b0;
        wait_idle();
        chk(nstart[d] == c0 + int'(acc), acc ? "R5 one start pulse" : "R3/R4 no start when untagged",
            64'(nstart[d] - c0), 64'(acc));
        chk(dead_cnt == dead0, "R9 no drop with idle digitizer", 64'(dead_cnt), 64'(dead0));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!fin) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rec_t ra, rb;
        void'($urandom(32'd2718));
        conv_dly[0] = 0; conv_dly[1] = 0;
        nstart[0] = 0; nstart[1] = 0;
        cd_pend[0] = 0; cd_pend[1] = 0;
        cd_cnt[0] = 0; cd_cnt[1] = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'd0);
        chk(dead_cnt == 16'd0, "R1 dead_cnt after reset", 64'(dead_cnt), 64'd0);
        chk(conv_start == 2'b00, "R1 conv_start after reset", 64'(conv_start), 64'd0);

        // first hit lands on digitizer 0 (R2), two channels, mid-window tag
        single_hit(4'b0101, 3, 2, 1'b1, 4);

        // R12/R11/R9: two triggers a cycle apart, one shared tag, third trigger dropped
        rdy_pct = 60;
        @(negedge clk);
        win_ticks = 8'd4;
        chan_mask = 4'b0011;
        conv_dly[int'(bpref)] = 20;
        trig = 1'b1;
        ra.ts = bcyc[47:0]; ra.dig = bpref; ra.mask = 4'b0011;
        bpref = ~bpref;
        @(negedge clk);
        chan_mask = 4'b1000;
        conv_dly[int'(bpref)] = 0;
        trig = 1'b1;
        rb.ts = bcyc[47:0]; rb.dig = bpref; rb.mask = 4'b1000;
        bpref = ~bpref;
        expq.push_back(rb);
        expq.push_back(ra);
        @(negedge clk);
        trig = 1'b0;
        coinc_tag = 1'b1;
        @(negedge clk);
        coinc_tag = 1'b0;
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        chk(dead_cnt == 16'd1, "R9 drop when both busy", 64'(dead_cnt), 64'd1);
        wait_idle();

        // R3 window edges
        rdy_pct = 100;
        single_hit(4'b0001, 0, 1, 1'b1, 2);
        single_hit(4'b0010, 5, 5, 1'b1, 0);
        single_hit(4'b0100, 5, 6, 1'b1, 2);
        single_hit(4'b1111, 6, 3, 1'b0, 2);
        single_hit(4'b0000, 2, 1, 1'b1, 1);

        // random isolated hits
        for (int n = 0; n < 24; n++) begin
            rdy_pct = 50 + int'($urandom % 51);
            single_hit(4'($urandom % 16), int'($urandom % 8), 1 + int'($urandom % 10),
                       ($urandom % 4) != 0, int'($urandom % 12));
        end

        // R9 saturation, then R11 tie broken by timestamp
        rdy_pct = 100;
        @(negedge clk);
        win_ticks = 8'd2;
        chan_mask = 4'b0000;
        conv_dly[0] = 70000; conv_dly[1] = 70000;
        trig = 1'b1;
        ra.ts = bcyc[47:0]; ra.dig = bpref; ra.mask = 4'b0000;
        bpref = ~bpref;
        @(negedge clk);
        rb.ts = bcyc[47:0]; rb.dig = bpref; rb.mask = 4'b0000;
        bpref = ~bpref;
        expq.push_back(ra);
        expq.push_back(rb);
        @(negedge clk);
        trig = 1'b0;
        coinc_tag = 1'b1;
        @(negedge clk);
        coinc_tag = 1'b0;
        trig = 1'b1;
        repeat (66000) @(negedge clk);
        trig = 1'b0;
        @(negedge clk);
        chk(dead_cnt == 16'hFFFF, "R9 saturation", 64'(dead_cnt), 64'hFFFF);
        wait_idle();
        chk(dead_cnt == 16'hFFFF, "R9 saturation held", 64'(dead_cnt), 64'hFFFF);
        chk(expq.size() == 0, "R11 all records delivered", 64'(expq.size()), 64'd0);

        fin = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule